// File: doc/BRIEF.md
# Serial Interface Status Flag Unit

This block keeps the status flags of a quad-SPI host controller and presents them to software as one 32-bit read-only word. The datapath reports what happens through single-cycle event strobes and a few level inputs: a receive register load, transmit data moving into the shifter, shifter idle, chip-select level, instruction end, enable and disable commands, and transfer-delay completion. The bus side reports three accesses: a status-word read, a receive-data read and a transmit-data write. Each flag has its own clear source, which depends on the flag's meaning.

Some flags are sticky and clear when the status word is read. Some clear on a data-register access. Two are live levels. Overrun is found by tracking whether the receive register is reloaded before it has been read. The all-transmit-empty flag can be made to wait for the inter-transfer delay. A status read captures the word into an output register in the read cycle, before any clear takes effect.

Every pin is a plain control or status signal. Strobes are sampled on every rising clock edge. There is no valid/ready pairing and no back-pressure: the block never stalls its sources and accepts an access in any cycle.

Top module: `qsf_status_unit`

## Requirements
- R1: The status word has receive-full at bit 0, transmit-ready at bit 1, all-transmit-empty at bit 2, overrun at bit 3, chip-select-rise at bit 8, chip-select-status at bit 9, instruction-end at bit 10 and enable-status at bit 24. All other bits read 0, and all flags and the read register reset to 0.
- R2: Receive-full becomes 1 in the cycle after `rx_load` and 0 in the cycle after `rxd_rd`. When both arrive in one cycle, it stays 1.
- R3: Overrun becomes 1 when `rx_load` arrives while receive-full is 1 and no `rxd_rd` comes in the same cycle. It stays 1 until a status read.
- R4: Transmit-ready is 0 after reset. The enable command sets it to 1, and `tx_shift` sets it to 1 while enabled. `txd_wr` clears it, and a write wins over a same-cycle `tx_shift`.
- R5: All-transmit-empty clears on `txd_wr`. It sets one cycle after transmit-ready is 1 with `shifter_idle` high. When `dly_cfg` is 1, it also needs a `dly_done` seen since the last transmit write.
- R6: Chip-select-rise sets when `cs_inactive` goes from 0 to 1 and clears on a status read.
- R7: Chip-select-status equals the value `cs_inactive` had at the previous clock edge (1 means deasserted).
- R8: Instruction-end sets on `instr_done` and clears on a status read.
- R9: Enable-status becomes 1 on `en_cmd` and 0 on `dis_cmd`. When both arrive in one cycle, the disable wins.
- R10: `sts_rd` loads the current word into `sts_rdata` one cycle later. That value is taken before the read clears anything. Without a read, `sts_rdata` holds its value.
- R11: An event that arrives in the same cycle as the status read that would clear its flag (chip-select-rise, instruction-end, overrun) leaves the flag at 1.
- R12: `dis_cmd` forces transmit-ready to 0 and leaves receive-full, overrun, all-transmit-empty and the sticky flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_load | input | 1 | Receive register loaded from the serializer |
| tx_shift | input | 1 | Transmit data moved into the shifter |
| shifter_idle | input | 1 | Level: the shifter holds no data |
| cs_inactive | input | 1 | Level: chip select deasserted |
| instr_done | input | 1 | Instruction end event |
| en_cmd | input | 1 | Enable command |
| dis_cmd | input | 1 | Disable command |
| dly_done | input | 1 | Inter-transfer delay finished |
| dly_cfg | input | 1 | Level: an inter-transfer delay is configured |
| sts_rd | input | 1 | Status word read strobe |
| rxd_rd | input | 1 | Receive data read strobe |
| txd_wr | input | 1 | Transmit data write strobe |
| sts_rdata | output | 32 | Registered status word returned by the last read |

## Verification
The bench targets same-cycle collisions:
- A load together with a receive read. A design that gives the clear priority drops receive-full; one that ignores the read reports a false overrun.
- An instruction end, a chip-select rise or a second load that meets a status read. A design that lets the clear win loses the event.
- A transmit write together with a shift. Here a wrong priority leaves transmit-ready set over unsent data.

It also checks that a configured delay holds off all-transmit-empty until the delay is done. It checks that enable and disable arriving together leave the controller disabled, and that a read returns the value from before its own clear rather than after.

// File: rtl/qsf_pkg.sv
package qsf_pkg;
  localparam int STS_W     = 32;
  localparam int B_RXF     = 0;
  localparam int B_TDRE    = 1;
  localparam int B_TXE     = 2;
  localparam int B_OVR     = 3;
  localparam int B_CSR     = 8;
  localparam int B_CSS     = 9;
  localparam int B_INS     = 10;
  localparam int B_ENS     = 24;
  localparam int N_STICKY  = 2;
  localparam int STK_CSR   = 0;
  localparam int STK_INS   = 1;
  localparam logic [STS_W-1:0] USED_MASK =
    (STS_W'(1) << B_RXF) | (STS_W'(1) << B_TDRE) | (STS_W'(1) << B_TXE) |
    (STS_W'(1) << B_OVR) | (STS_W'(1) << B_CSR)  | (STS_W'(1) << B_CSS) |
    (STS_W'(1) << B_INS) | (STS_W'(1) << B_ENS);

  typedef struct packed {
    logic rxf;
    logic tdre;
    logic txe;
    logic ovr;
    logic csr;
    logic css;
    logic ins;
    logic ens;
  } qsf_flags_t;
endpackage

// File: rtl/qsf_sticky.sv
// Sticky flag: set wins over a same-cycle clear so no event is lost.
module qsf_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/qsf_rx_track.sv
// Receive-full and overrun tracking.
module qsf_rx_track (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic data_rd_i,
  input  logic sts_rd_i,
  output logic full_o,
  output logic ovr_o
);
  logic ovr_set;

  // A reload while still full and not drained this cycle is an overrun.
  assign ovr_set = load_i & full_o & ~data_rd_i;

  always_ff @(posedge clk) begin
    if (!rst_n)         full_o <= 1'b0;
    else if (load_i)    full_o <= 1'b1;
    else if (data_rd_i) full_o <= 1'b0;
  end

  qsf_sticky u_ovr (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (ovr_set),
    .clr_i (sts_rd_i),
    .q_o   (ovr_o)
  );
endmodule

// File: rtl/qsf_tx_track.sv
// Transmit-ready and all-transmit-empty tracking with optional delay gate.
module qsf_tx_track (
  input  logic clk,
  input  logic rst_n,
  input  logic enabled_i,
  input  logic en_cmd_i,
  input  logic dis_cmd_i,
  input  logic wr_i,
  input  logic shift_i,
  input  logic idle_i,
  input  logic dly_cfg_i,
  input  logic dly_done_i,
  output logic tdre_o,
  output logic txe_o
);
  logic dly_seen;
  logic txe_set;

  assign txe_set = tdre_o & idle_i & (~dly_cfg_i | dly_seen) & ~wr_i;

  always_ff @(posedge clk) begin
    if (!rst_n)                      tdre_o <= 1'b0;
    else if (dis_cmd_i)              tdre_o <= 1'b0;
    else if (wr_i)                   tdre_o <= 1'b0;
    else if (en_cmd_i)               tdre_o <= 1'b1;
    else if (shift_i && enabled_i)   tdre_o <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          dly_seen <= 1'b0;
    else if (wr_i)       dly_seen <= 1'b0;
    else if (dly_done_i) dly_seen <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       txe_o <= 1'b0;
    else if (wr_i)    txe_o <= 1'b0;
    else if (txe_set) txe_o <= 1'b1;
  end
endmodule

// File: rtl/qsf_status_unit.sv
module qsf_status_unit
  import qsf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_load,
  input  logic             tx_shift,
  input  logic             shifter_idle,
  input  logic             cs_inactive,
  input  logic             instr_done,
  input  logic             en_cmd,
  input  logic             dis_cmd,
  input  logic             dly_done,
  input  logic             dly_cfg,
  input  logic             sts_rd,
  input  logic             rxd_rd,
  input  logic             txd_wr,
  output logic [STS_W-1:0] sts_rdata
);
  qsf_flags_t          flg;
  logic                cs_q;
  logic                armed;
  logic                ens_q;
  logic [N_STICKY-1:0] stk_set;
  logic [N_STICKY-1:0] stk_q;
  logic [STS_W-1:0]    sts_word;

  // Chip-select sampling; rise detection waits one edge after reset.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q  <= 1'b0;
      armed <= 1'b0;
    end else begin
      cs_q  <= cs_inactive;
      armed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ens_q <= 1'b0;
    else if (dis_cmd) ens_q <= 1'b0;
    else if (en_cmd)  ens_q <= 1'b1;
  end

  always_comb begin
    stk_set          = '0;
    stk_set[STK_CSR] = armed & cs_inactive & ~cs_q;
    stk_set[STK_INS] = instr_done;
  end

  for (genvar g = 0; g < N_STICKY; g++) begin : g_stk
    qsf_sticky u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (stk_set[g]),
      .clr_i (sts_rd),
      .q_o   (stk_q[g])
    );
  end

  qsf_rx_track u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (rx_load),
    .data_rd_i (rxd_rd),
    .sts_rd_i  (sts_rd),
    .full_o    (flg.rxf),
    .ovr_o     (flg.ovr)
  );

  qsf_tx_track u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .enabled_i  (ens_q),
    .en_cmd_i   (en_cmd),
    .dis_cmd_i  (dis_cmd),
    .wr_i       (txd_wr),
    .shift_i    (tx_shift),
    .idle_i     (shifter_idle),
    .dly_cfg_i  (dly_cfg),
    .dly_done_i (dly_done),
    .tdre_o     (flg.tdre),
    .txe_o      (flg.txe)
  );

  assign flg.csr = stk_q[STK_CSR];
  assign flg.ins = stk_q[STK_INS];
  assign flg.css = cs_q;
  assign flg.ens = ens_q;

  always_comb begin
    sts_word         = '0;
    sts_word[B_RXF]  = flg.rxf;
    sts_word[B_TDRE] = flg.tdre;
    sts_word[B_TXE]  = flg.txe;
    sts_word[B_OVR]  = flg.ovr;
    sts_word[B_CSR]  = flg.csr;
    sts_word[B_CSS]  = flg.css;
    sts_word[B_INS]  = flg.ins;
    sts_word[B_ENS]  = flg.ens;
  end

  // Captured from the pre-clear state in the read cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)      sts_rdata <= '0;
    else if (sts_rd) sts_rdata <= sts_word;
  end
endmodule

// File: rtl/qsf_status_chk.sv
module qsf_status_chk
  import qsf_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             rx_load,
  input logic             rxd_rd,
  input logic             sts_rd,
  input logic             dis_cmd,
  input logic             en_cmd,
  input logic             txd_wr,
  input logic             instr_done,
  input logic             cs_inactive,
  input logic             armed,
  input logic [STS_W-1:0] sts_word,
  input logic [STS_W-1:0] sts_rdata
);
  // R1: unused bits of the returned word stay zero
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rdata & ~USED_MASK) == '0);

  // R2: a load makes receive-full visible next cycle
  a_r2_rxf_set: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> sts_word[B_RXF]);

  // R3: reload while full without a drain flags overrun
  a_r3_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_load && sts_word[B_RXF] && !rxd_rd) |=> sts_word[B_OVR]);

  // R3: overrun persists until a status read
  a_r3_ovr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_word[B_OVR] && !sts_rd) |=> sts_word[B_OVR]);

  // R4: disable forces transmit-ready low
  a_r4_tdre_dis: assert property (@(posedge clk) disable iff (!rst_n)
    dis_cmd |=> !sts_word[B_TDRE]);

  // R5: a transmit write clears all-transmit-empty
  a_r5_txe_wr: assert property (@(posedge clk) disable iff (!rst_n)
    txd_wr |=> !sts_word[B_TXE]);

  // R7: chip-select-status follows the sampled input
  a_r7_css_level: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (sts_word[B_CSS] == $past(cs_inactive)));

  // R9: disable wins over a same-cycle enable
  a_r9_dis_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_cmd && en_cmd) |=> !sts_word[B_ENS]);

  // R10: a read returns the pre-clear word
  a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
    sts_rd |=> (sts_rdata == $past(sts_word)));

  // R11: instruction end colliding with a status read is kept
  a_r11_ins_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && sts_rd) |=> sts_word[B_INS]);
endmodule

bind qsf_status_unit qsf_status_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_load     (rx_load),
  .rxd_rd      (rxd_rd),
  .sts_rd      (sts_rd),
  .dis_cmd     (dis_cmd),
  .en_cmd      (en_cmd),
  .txd_wr      (txd_wr),
  .instr_done  (instr_done),
  .cs_inactive (cs_inactive),
  .armed       (armed),
  .sts_word    (sts_word),
  .sts_rdata   (sts_rdata)
);

// File: tb/tb_qsf_status_unit.sv
module tb_qsf_status_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_load = 0, tx_shift = 0, shifter_idle = 0, cs_inactive = 0;
  logic instr_done = 0, en_cmd = 0, dis_cmd = 0, dly_done = 0, dly_cfg = 0;
  logic sts_rd = 0, rxd_rd = 0, txd_wr = 0;
  logic [31:0] sts_rdata;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  qsf_status_unit dut (
    .clk(clk), .rst_n(rst_n), .rx_load(rx_load), .tx_shift(tx_shift),
    .shifter_idle(shifter_idle), .cs_inactive(cs_inactive),
    .instr_done(instr_done), .en_cmd(en_cmd), .dis_cmd(dis_cmd),
    .dly_done(dly_done), .dly_cfg(dly_cfg), .sts_rd(sts_rd),
    .rxd_rd(rxd_rd), .txd_wr(txd_wr), .sts_rdata(sts_rdata)
  );

  // stimulus bit positions
  localparam logic [10:0] S_RXL  = 11'h001;
  localparam logic [10:0] S_TXSH = 11'h002;
  localparam logic [10:0] S_IDLE = 11'h004;
  localparam logic [10:0] S_CSI  = 11'h008;
  localparam logic [10:0] S_IEND = 11'h010;
  localparam logic [10:0] S_EN   = 11'h020;
  localparam logic [10:0] S_DIS  = 11'h040;
  localparam logic [10:0] S_DD   = 11'h080;
  localparam logic [10:0] S_DCFG = 11'h100;
  localparam logic [10:0] S_RRD  = 11'h200;
  localparam logic [10:0] S_TWR  = 11'h400;

  // {requirement, expected word, stimulus}
  localparam int NV = 20;
  localparam logic [46:0] VEC [NV] = '{
    {4'd6,  32'h0000_0300, S_IDLE|S_CSI},                 // R6 R7
    {4'd9,  32'h0100_0202, S_IDLE|S_CSI|S_EN},            // R9 R4
    {4'd5,  32'h0100_0206, S_IDLE|S_CSI},                 // R5
    {4'd5,  32'h0100_0200, S_IDLE|S_CSI|S_TWR},           // R5 R4
    {4'd4,  32'h0100_0202, S_CSI|S_TXSH},                 // R4
    {4'd5,  32'h0100_0202, S_IDLE|S_CSI|S_DCFG},          // R5 delay pending
    {4'd5,  32'h0100_0202, S_IDLE|S_CSI|S_DCFG|S_DD},     // R5
    {4'd5,  32'h0100_0206, S_IDLE|S_CSI|S_DCFG},          // R5
    {4'd2,  32'h0100_0207, S_IDLE|S_CSI|S_DCFG|S_RXL},    // R2
    {4'd3,  32'h0100_020F, S_IDLE|S_CSI|S_DCFG|S_RXL},    // R3
    {4'd2,  32'h0100_0206, S_IDLE|S_CSI|S_DCFG|S_RRD},    // R2 R3
    {4'd2,  32'h0100_0207, S_IDLE|S_CSI|S_DCFG|S_RXL},    // R2
    {4'd2,  32'h0100_0207, S_IDLE|S_CSI|S_DCFG|S_RXL|S_RRD}, // R2 R3
    {4'd8,  32'h0100_0607, S_IDLE|S_CSI|S_DCFG|S_IEND},   // R8
    {4'd7,  32'h0100_0007, S_IDLE|S_DCFG},                // R7
    {4'd6,  32'h0100_0307, S_IDLE|S_CSI|S_DCFG},          // R6
    {4'd12, 32'h0000_0205, S_IDLE|S_CSI|S_DCFG|S_DIS},    // R12 R9
    {4'd9,  32'h0000_0205, S_IDLE|S_CSI|S_DCFG|S_EN|S_DIS}, // R9
    {4'd2,  32'h0000_0204, S_IDLE|S_CSI|S_DCFG|S_RRD},    // R2
    {4'd5,  32'h0000_0200, S_IDLE|S_CSI|S_DCFG|S_TWR}     // R5
  };

  task automatic drive(input logic [10:0] s, input logic rd);
    rx_load = s[0]; tx_shift = s[1]; shifter_idle = s[2]; cs_inactive = s[3];
    instr_done = s[4]; en_cmd = s[5]; dis_cmd = s[6]; dly_done = s[7];
    dly_cfg = s[8]; rxd_rd = s[9]; txd_wr = s[10]; sts_rd = rd;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] exp);
    total++;
    if (sts_rdata !== exp) begin
      bad++;
      $display("FAIL %s: sts_rdata=%h expected=%h", req, sts_rdata, exp);
    end
  endtask

  localparam logic [10:0] LV = S_IDLE|S_CSI|S_DCFG;

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 32'h0);                // reset value
    rst_n = 1'b1;
    drive(11'h0, 1'b0);
    drive(11'h0, 1'b0);
    check("R1", 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [10:0] lv;
      lv = VEC[i][10:0] & (S_IDLE|S_CSI|S_DCFG);
      drive(VEC[i][10:0], 1'b0);
      drive(lv, 1'b1);
      check($sformatf("R%0d vec%0d", VEC[i][46:43], i), VEC[i][42:11]);
    end

    // R11: instruction end meets a status read; read shows pre-set value
    drive(LV|S_IEND, 1'b1);
    check("R10", 32'h0000_0200);
    drive(LV, 1'b1);
    check("R11", 32'h0000_0600);
    drive(LV, 1'b1);
    check("R8", 32'h0000_0200);

    // R11: overrun meets a status read
    drive(LV|S_RXL, 1'b0);
    drive(LV|S_RXL, 1'b1);
    check("R10", 32'h0000_0201);
    drive(LV, 1'b1);
    check("R11", 32'h0000_0209);
    drive(LV, 1'b1);
    check("R3", 32'h0000_0201);

    // R10: no read, returned word holds
    drive(LV|S_IEND, 1'b0);
    check("R10", 32'h0000_0201);

    // R11: chip-select rise meets a status read
    drive(S_IDLE|S_DCFG, 1'b0);
    drive(LV, 1'b1);
    check("R10", 32'h0000_0401);
    drive(LV, 1'b1);
    check("R11", 32'h0000_0301);

    // R4: write and shift together while enabled leaves ready low
    drive(LV|S_EN, 1'b0);
    drive(LV|S_TWR|S_TXSH, 1'b0);
    drive(LV, 1'b1);
    check("R4", 32'h0100_0201);

    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: expired before completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule